// File: doc/BRIEF.md
# Line Activation State Machine

This block supervises the physical-layer activation of a subscriber-side basic-rate line. It receives 4-bit status codes from the line transceiver, activate and deactivate requests from the upper layer, and the expiry of its own supervision timer. It tracks the line through nine states and answers each event with a 4-bit command to the transceiver and, where the event calls for it, an activation or deactivation notice to the upper layer.

All inputs are sampled on the rising clock edge. All outputs are registered and hold for one cycle. When several event sources are active in the same cycle, exactly one is consumed. A transceiver status code always wins. A local activate request comes next, then a local deactivate request, and timer expiry comes last.

Top module: `line_act_ctrl`

## Requirements
- R1: After reset `state_code` reads 0, and `cmd_valid`, `act_ind` and `deact_ind` are low.
- R2: `state_code` encodes the states as follows: 0 reset, 1 idle powered down, 2 idle powered up, 3 pending deactivation, 4 F4, 5 F5, 6 F6, 7 F7 (active), 8 F8.
- R3: Status 0001 or 0110 in any state moves to reset and issues command 1111. A deactivation notice is raised only when the state left was F7.
- R4: Status 1100 in any state other than F7 moves to F7, stops the supervision timer, issues command 1000 and raises an activation notice. In F7 the status has no effect.
- R5: An activate request in state 1 issues command 1000 and (re)starts the supervision timer, and the state does not change. In every other state the request has no effect.
- R6: `SUP_CYCLES` cycles after the command pulse of the last timer start, the timer expires. If the state is then 1, 4, 5, 6 or 8, the block issues command 1111 and a deactivation notice without changing state. In other states the expiry has no effect. The timer fires once per start.
- R7: Status 1111 moves states 0, 3, 4, 5, 6 and 8 to state 1. Status 0111 moves state 1 to F4.
- R8: Status 0100 moves states 1, 3 and 4 to F5 and moves F6 to F8. From F7 it moves to F8 and raises a deactivation notice.
- R9: Status 1000 moves every state except F4 to F6. It raises a deactivation notice when it leaves F7.
- R10: Status 0000 from F5 or F8, and status 0101 from F6, move to state 3 and issue command 1111. Status 0000 from F7 does the same and also raises a deactivation notice.
- R11: Codes 0010, 0011, 1001, 1010, 1011, 1101 and 1110, every state and event pair not listed above, and the deactivate request leave the state unchanged and produce no pulse.
- R12: Responses appear in the cycle after the event is sampled and last one cycle. A command and a notice from the same event share that cycle. `cmd_code` is 0 when no command is issued.
- R13: When a status code and a local request arrive together, only the status code is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_valid | input | 1 | Status code from transceiver is present |
| ind_code | input | 4 | Transceiver status code |
| act_req | input | 1 | Upper-layer activate request (one cycle) |
| deact_req | input | 1 | Upper-layer deactivate request (one cycle) |
| cmd_valid | output | 1 | Command to transceiver, one-cycle pulse |
| cmd_code | output | 4 | Command code (1000 activate, 1111 disable) |
| act_ind | output | 1 | Activation notice to upper layer |
| deact_ind | output | 1 | Deactivation notice to upper layer |
| state_code | output | 4 | Current state, encoded per R2 |

## Verification
The properties assume that `ind_code` matters only while `ind_valid` is high. They also assume that every input is synchronous to `clk` and changes only between rising edges. Requests and status codes are treated as single-cycle events, so a level held for several cycles counts as repeated events. The stimulus changes every input on the falling edge and holds it for exactly one cycle before clearing it. It only combines a status code with a request when it is probing the priority rule.

// File: rtl/line_act_pkg.sv
package line_act_pkg;

    typedef enum logic [3:0] {
        ST_RESET = 4'd0,
        ST_PDOWN = 4'd1,
        ST_PUP   = 4'd2,
        ST_PEND  = 4'd3,
        ST_F4    = 4'd4,
        ST_F5    = 4'd5,
        ST_F6    = 4'd6,
        ST_F7    = 4'd7,
        ST_F8    = 4'd8
    } act_state_e;

    // transceiver status codes
    localparam logic [3:0] LS_LINE_DEACT = 4'b0000;
    localparam logic [3:0] LS_LINE_RESET = 4'b0001;
    localparam logic [3:0] LS_RESYNC     = 4'b0100;
    localparam logic [3:0] LS_DEACT_F6   = 4'b0101;
    localparam logic [3:0] LS_ERROR      = 4'b0110;
    localparam logic [3:0] LS_POWER_UP   = 4'b0111;
    localparam logic [3:0] LS_ACT_REQ    = 4'b1000;
    localparam logic [3:0] LS_ACT_IND    = 4'b1100;
    localparam logic [3:0] LS_DEACT_CONF = 4'b1111;

    // transceiver commands
    localparam logic [3:0] TC_ACTIVATE   = 4'b1000;
    localparam logic [3:0] TC_DISABLE    = 4'b1111;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_LINE,
        EV_LOCAL_ACT,
        EV_LOCAL_DEACT,
        EV_EXPIRY
    } ev_src_e;

    typedef struct packed {
        act_state_e state;
        logic       cmd_v;
        logic [3:0] cmd;
        logic       up_act;
        logic       up_deact;
    } core_regs_t;

    typedef struct packed {
        logic run;
        logic [31:0] cnt;
    } tmr_wide_t;

endpackage

// File: rtl/act_sup_timer.sv
module act_sup_timer
    import line_act_pkg::*;
#(
    parameter int SUP_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic expire
);
    localparam int CW = (SUP_CYCLES > 1) ? $clog2(SUP_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SUP_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (stop) begin
            tmr_d.run = 1'b0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.run && !start && !stop && tmr_q.cnt != '0
        |=> tmr_q.run && tmr_q.cnt == $past(tmr_q.cnt) - 1'b1);

    assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !start |=> !expire);

    assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !start |=> !expire);

endmodule

// File: rtl/act_evt_sel.sv
module act_evt_sel
    import line_act_pkg::*;
(
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       deact_req,
    input  logic       expire,
    output ev_src_e    ev_src,
    output logic [3:0] ev_code
);
    always_comb begin
        ev_code = ind_code;
        if (ind_valid)      ev_src = EV_LINE;
        else if (act_req)   ev_src = EV_LOCAL_ACT;
        else if (deact_req) ev_src = EV_LOCAL_DEACT;
        else if (expire)    ev_src = EV_EXPIRY;
        else                ev_src = EV_NONE;
    end
endmodule

// File: rtl/act_fsm_core.sv
module act_fsm_core
    import line_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ev_src_e    ev_src,
    input  logic [3:0] ev_code,
    output act_state_e state,
    output logic       cmd_v,
    output logic [3:0] cmd,
    output logic       up_act,
    output logic       up_deact,
    output logic       tmr_start,
    output logic       tmr_stop
);
    core_regs_t r_d, r_q;

    logic in_f7;
    logic watch_state;
    assign in_f7 = (r_q.state == ST_F7);
    // states in which a supervision expiry is acted on
    assign watch_state = (r_q.state == ST_PDOWN) || (r_q.state == ST_F4) ||
                         (r_q.state == ST_F5)    || (r_q.state == ST_F6) ||
                         (r_q.state == ST_F8);

    always_comb begin
        r_d          = r_q;
        r_d.cmd_v    = 1'b0;
        r_d.cmd      = '0;
        r_d.up_act   = 1'b0;
        r_d.up_deact = 1'b0;
        tmr_start    = 1'b0;
        tmr_stop     = 1'b0;
        unique case (ev_src)
            EV_LINE: begin
                unique case (ev_code)
                    LS_LINE_RESET, LS_ERROR: begin
                        r_d.state    = ST_RESET;
                        r_d.cmd_v    = 1'b1;
                        r_d.cmd      = TC_DISABLE;
                        r_d.up_deact = in_f7;
                    end
                    LS_ACT_IND: begin
                        if (!in_f7) begin
                            r_d.state  = ST_F7;
                            r_d.cmd_v  = 1'b1;
                            r_d.cmd    = TC_ACTIVATE;
                            r_d.up_act = 1'b1;
                            tmr_stop   = 1'b1;
                        end
                    end
                    LS_DEACT_CONF: begin
                        if (r_q.state inside {ST_RESET, ST_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
                            r_d.state = ST_PDOWN;
                    end
                    LS_POWER_UP: begin
                        if (r_q.state == ST_PDOWN) r_d.state = ST_F4;
                    end
                    LS_RESYNC: begin
                        if (r_q.state inside {ST_PDOWN, ST_PEND, ST_F4})
                            r_d.state = ST_F5;
                        else if (r_q.state == ST_F6)
                            r_d.state = ST_F8;
                        else if (in_f7) begin
                            r_d.state    = ST_F8;
                            r_d.up_deact = 1'b1;
                        end
                    end
                    LS_ACT_REQ: begin
                        if (r_q.state != ST_F4) begin
                            r_d.state    = ST_F6;
                            r_d.up_deact = in_f7;
                        end
                    end
                    LS_LINE_DEACT: begin
                        if (r_q.state inside {ST_F5, ST_F7, ST_F8}) begin
                            r_d.state    = ST_PEND;
                            r_d.cmd_v    = 1'b1;
                            r_d.cmd      = TC_DISABLE;
                            r_d.up_deact = in_f7;
                        end
                    end
                    LS_DEACT_F6: begin
                        if (r_q.state == ST_F6) begin
                            r_d.state = ST_PEND;
                            r_d.cmd_v = 1'b1;
                            r_d.cmd   = TC_DISABLE;
                        end
                    end
                    default: ;
                endcase
            end
            EV_LOCAL_ACT: begin
                if (r_q.state == ST_PDOWN) begin
                    r_d.cmd_v = 1'b1;
                    r_d.cmd   = TC_ACTIVATE;
                    tmr_start = 1'b1;
                end
            end
            EV_EXPIRY: begin
                if (watch_state) begin
                    r_d.cmd_v    = 1'b1;
                    r_d.cmd      = TC_DISABLE;
                    r_d.up_deact = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_RESET, cmd_v: 1'b0, cmd: 4'd0, up_act: 1'b0, up_deact: 1'b0};
        else        r_q <= r_d;
    end

    assign state    = r_q.state;
    assign cmd_v    = r_q.cmd_v;
    assign cmd      = r_q.cmd;
    assign up_act   = r_q.up_act;
    assign up_deact = r_q.up_deact;

    assert_reset_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_src == EV_LINE && (ev_code == LS_LINE_RESET || ev_code == LS_ERROR)
        |=> r_q.state == ST_RESET && r_q.cmd_v && r_q.cmd == TC_DISABLE);

    assert_act_notice_in_f7_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.up_act |-> r_q.state == ST_F7 && r_q.cmd_v && r_q.cmd == TC_ACTIVATE);

    assert_local_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_src == EV_LOCAL_ACT && r_q.state == ST_PDOWN
        |=> r_q.state == ST_PDOWN && r_q.cmd_v && r_q.cmd == TC_ACTIVATE);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_src == EV_NONE |=> !r_q.cmd_v && !r_q.up_act && !r_q.up_deact && $stable(r_q.state));

    assert_notice_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.up_act, r_q.up_deact}));

    assert_no_idle_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.cmd_v |-> r_q.cmd == 4'd0);

endmodule

// File: rtl/line_act_ctrl.sv
module line_act_ctrl
    import line_act_pkg::*;
#(
    parameter int SUP_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       deact_req,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       act_ind,
    output logic       deact_ind,
    output logic [3:0] state_code
);
    ev_src_e    sel_src;
    logic [3:0] sel_code;
    logic       tmr_expire;
    logic       tmr_start;
    logic       tmr_stop;
    act_state_e cur_state;

    act_evt_sel u_sel (
        .ind_valid (ind_valid),
        .ind_code  (ind_code),
        .act_req   (act_req),
        .deact_req (deact_req),
        .expire    (tmr_expire),
        .ev_src    (sel_src),
        .ev_code   (sel_code)
    );

    act_sup_timer #(.SUP_CYCLES(SUP_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .stop   (tmr_stop),
        .expire (tmr_expire)
    );

    act_fsm_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_src    (sel_src),
        .ev_code   (sel_code),
        .state     (cur_state),
        .cmd_v     (cmd_valid),
        .cmd       (cmd_code),
        .up_act    (act_ind),
        .up_deact  (deact_ind),
        .tmr_start (tmr_start),
        .tmr_stop  (tmr_stop)
    );

    assign state_code = cur_state;

    assert_line_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ind_valid && act_req && ind_code != LS_ACT_IND
        |=> !(cmd_valid && cmd_code == TC_ACTIVATE));

    assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 4'd8);

endmodule

// File: tb/sim_line_act_ctrl.sv
module sim_line_act_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  SUP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ind_valid = 1'b0;
    logic [3:0] ind_code = 4'd0;
    logic       act_req = 1'b0;
    logic       deact_req = 1'b0;
    logic       cmd_valid;
    logic [3:0] cmd_code;
    logic       act_ind;
    logic       deact_ind;
    logic [3:0] state_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         due;
        logic       cv;
        logic [3:0] cc;
        logic       a;
        logic       d;
        logic [3:0] st;
        string      tag;
    } exp_t;

    exp_t sb[$];

    line_act_ctrl #(.SUP_CYCLES(SUP)) u0 (
        .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
        .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .act_ind(act_ind), .deact_ind(deact_ind),
        .state_code(state_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expectations as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks = checks + 1;
            if (cmd_valid !== e.cv || cmd_code !== e.cc || act_ind !== e.a ||
                deact_ind !== e.d || state_code !== e.st) begin
                errors = errors + 1;
                $display("FAIL %s: got cv=%b cmd=%b act=%b deact=%b st=%0d, expected cv=%b cmd=%b act=%b deact=%b st=%0d",
                         e.tag, cmd_valid, cmd_code, act_ind, deact_ind, state_code,
                         e.cv, e.cc, e.a, e.d, e.st);
            end
        end
    end

    // driver: one stimulus cycle plus its expected response
    task automatic step(input logic iv, input logic [3:0] ic, input logic ar, input logic dr,
                        input logic ecv, input logic [3:0] ec, input logic ea, input logic ed,
                        input logic [3:0] es, input string tag);
        exp_t e;
        ind_valid = iv; ind_code = ic; act_req = ar; deact_req = dr;
        e.due = cyc + 1; e.cv = ecv; e.cc = ec; e.a = ea; e.d = ed; e.st = es; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        ind_valid = 1'b0; ind_code = 4'd0; act_req = 1'b0; deact_req = 1'b0;
    endtask

    task automatic ind(input logic [3:0] c, input logic ecv, input logic [3:0] ec,
                       input logic ea, input logic ed, input logic [3:0] es, input string tag);
        step(1'b1, c, 1'b0, 1'b0, ecv, ec, ea, ed, es, tag);
    endtask

    task automatic idle(input int n, input logic [3:0] es, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, es, tag);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors = errors + 1;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1, 4'd0, "R1 reset state");
        // R11 unknown code, R7 to power down
        ind(4'b0010, 0, 4'd0, 0, 0, 4'd0, "R11 code 0010 ignored");
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R7 1111 reset->pdown");
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R11 1111 in pdown");
        step(0, 4'd0, 0, 1, 0, 4'd0, 0, 0, 4'd1, "R11 deact request ignored");
        // R5 + R6 timer in pdown
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 act request in pdown");
        idle(SUP - 1, 4'd1, "R6 quiet before expiry");
        idle(0, 4'd1, "");
        step(0, 4'd0, 0, 0, 1, 4'b1111, 0, 1, 4'd1, "R6 expiry in pdown");
        idle(SUP + 1, 4'd1, "R6 single fire");
        // walk the states
        ind(4'b0111, 0, 4'd0, 0, 0, 4'd4, "R7 0111 pdown->F4");
        step(0, 4'd0, 1, 0, 0, 4'd0, 0, 0, 4'd4, "R5 act request in F4 ignored");
        ind(4'b1000, 0, 4'd0, 0, 0, 4'd4, "R9 1000 in F4 ignored");
        ind(4'b0100, 0, 4'd0, 0, 0, 4'd5, "R8 0100 F4->F5");
        ind(4'b0000, 1, 4'b1111, 0, 0, 4'd3, "R10 0000 F5->pend");
        ind(4'b0100, 0, 4'd0, 0, 0, 4'd5, "R8 0100 pend->F5");
        ind(4'b1000, 0, 4'd0, 0, 0, 4'd6, "R9 1000 F5->F6");
        ind(4'b0100, 0, 4'd0, 0, 0, 4'd8, "R8 0100 F6->F8");
        ind(4'b0000, 1, 4'b1111, 0, 0, 4'd3, "R10 0000 F8->pend");
        ind(4'b1000, 0, 4'd0, 0, 0, 4'd6, "R9 1000 pend->F6");
        ind(4'b1001, 0, 4'd0, 0, 0, 4'd6, "R11 code 1001 ignored");
        ind(4'b1101, 0, 4'd0, 0, 0, 4'd6, "R11 code 1101 ignored");
        ind(4'b1110, 0, 4'd0, 0, 0, 4'd6, "R11 code 1110 ignored");
        ind(4'b0011, 0, 4'd0, 0, 0, 4'd6, "R11 code 0011 ignored");
        ind(4'b0101, 1, 4'b1111, 0, 0, 4'd3, "R10 0101 F6->pend");
        ind(4'b1100, 1, 4'b1000, 1, 0, 4'd7, "R4 1100 pend->F7");
        ind(4'b1100, 0, 4'd0, 0, 0, 4'd7, "R4 1100 in F7 ignored");
        ind(4'b0100, 0, 4'd0, 0, 1, 4'd8, "R8 0100 F7->F8 notice");
        ind(4'b1100, 1, 4'b1000, 1, 0, 4'd7, "R4 1100 F8->F7");
        ind(4'b1000, 0, 4'd0, 0, 1, 4'd6, "R9 1000 F7->F6 notice");
        ind(4'b1100, 1, 4'b1000, 1, 0, 4'd7, "R4 1100 F6->F7");
        ind(4'b0000, 1, 4'b1111, 0, 1, 4'd3, "R10 0000 F7->pend notice");
        ind(4'b1100, 1, 4'b1000, 1, 0, 4'd7, "R4 re-enter F7");
        ind(4'b0110, 1, 4'b1111, 0, 1, 4'd0, "R3 0110 from F7 notice");
        ind(4'b0001, 1, 4'b1111, 0, 0, 4'd0, "R3 0001 in reset no notice");
        // R13 priority
        step(1, 4'b1111, 1, 0, 0, 4'd0, 0, 0, 4'd1, "R13 status beats act request");
        step(1, 4'b0111, 1, 0, 0, 4'd0, 0, 0, 4'd4, "R13 status beats act request in pdown");
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R7 1111 F4->pdown");
        // R4 timer stop
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 timer start");
        ind(4'b1100, 1, 4'b1000, 1, 0, 4'd7, "R4 1100 pdown->F7");
        ind(4'b0100, 0, 4'd0, 0, 1, 4'd8, "R8 F7->F8");
        idle(SUP, 4'd8, "R4 stopped timer stays quiet");
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R7 1111 F8->pdown");
        // R6 expiry in F4
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 timer start");
        ind(4'b0111, 0, 4'd0, 0, 0, 4'd4, "R7 pdown->F4");
        idle(SUP - 2, 4'd4, "R6 quiet in F4");
        step(0, 4'd0, 0, 0, 1, 4'b1111, 0, 1, 4'd4, "R6 expiry in F4");
        // R6 expiry ignored in reset
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R7 F4->pdown");
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 timer start");
        ind(4'b0001, 1, 4'b1111, 0, 0, 4'd0, "R3 0001 pdown->reset");
        idle(SUP + 1, 4'd0, "R6 expiry ignored in reset");
        // R5 restart
        ind(4'b1111, 0, 4'd0, 0, 0, 4'd1, "R7 reset->pdown");
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 first start");
        idle(4, 4'd1, "R5 quiet");
        step(0, 4'd0, 1, 0, 1, 4'b1000, 0, 0, 4'd1, "R5 restart");
        idle(SUP - 1, 4'd1, "R5 restart delays expiry");
        step(0, 4'd0, 0, 0, 1, 4'b1111, 0, 1, 4'd1, "R6 expiry after restart");
        idle(2, 4'd1, "R12 pulse lasts one cycle");
        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            errors = errors + 1;
            $display("FAIL R12: got %0d pending, expected 0", sb.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule